// File: doc/BRIEF.md
# Mode-Configurable Multiply-Add Array

This block is a multiplier array built from four 18x18 lanes. Each lane can also split into two 9x9 multipliers. A three-bit mode input selects the operation for each cycle:

- independent products,
- sums of two products,
- sums of four products,
- two running accumulators,
- a single 36x36 product assembled from the four lanes.

A size input picks 9-bit or 18-bit operands for the first four modes. A sign input makes every operand signed two's complement or every operand unsigned.

Operands arrive as two 72-bit words. Results leave as one registered 144-bit word, split into equal fields whose width depends on the mode. Every field holds the exact arithmetic value, truncated or extended to the field's width. Signed mode extends with the sign bit and unsigned mode extends with zeros. The accumulators are 52 bits wide and wrap on overflow. A clear input loads the current sum, and an enable input adds it. The unit is meant to sit inside filter, correlator and transform datapaths, where it is reconfigured cycle by cycle.

Top module: `mul_mode_array`

## Requirements
- R1: While `rst_n` is low, `result` and both accumulators are zero.
- R2: `result` is registered. The value present after a rising edge reflects the inputs sampled at that edge, in every mode, and a mode change takes effect at the next edge.
- R3: Mode 0 (also 5, 6, 7) with `narrow`=0 gives four 18x18 products: `opa[18k+17:18k]` times `opb[18k+17:18k]` goes to `result[36k+35:36k]`.
- R4: Mode 0 with `narrow`=1 gives eight 9x9 products: `opa[9j+8:9j]` times `opb[9j+8:9j]` goes to `result[18j+17:18j]`, truncated to 18 bits.
- R5: Mode 1 with `narrow`=0 gives two sums: products 0+1 go to `result[71:0]` and products 2+3 go to `result[143:72]`.
- R6: Mode 1 with `narrow`=1 gives four sums of 9x9 products 2j and 2j+1, each in `result[36j+35:36j]`.
- R7: Mode 2 with `narrow`=0 gives the sum of all four 18x18 products across all 144 bits. With `narrow`=1 it gives the sums of 9x9 products 0..3 in `result[71:0]` and 4..7 in `result[143:72]`.
- R8: Mode 3 runs two 52-bit accumulators. Accumulator 0 takes products 0+1 (18-bit) or 9x9 products 0..3 (9-bit); accumulator 1 takes products 2+3 or 9x9 products 4..7. The new values appear in `result[51:0]` and `result[123:72]`, each extended to 72 bits by the sign mode.
- R9: In mode 3, `acc_clr`=1 loads the current sum into both accumulators, whatever the value of `acc_en`.
- R10: The accumulators hold their value when `acc_en` and `acc_clr` are both low, and in every mode other than 3.
- R11: Accumulation wraps modulo 2^52 without saturating.
- R12: Mode 4 multiplies `opa[35:0]` by `opb[35:0]` into a 72-bit product and ignores `narrow`. The product is extended to 144 bits by the sign mode.
- R13: `sgn_mode`=1 treats every operand as two's complement and `sgn_mode`=0 treats every operand as unsigned. Each field holds the exact value modulo 2 to the power of its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 3 | 0 products, 1 pair sums, 2 quad sums, 3 accumulate, 4 wide product |
| narrow | input | 1 | 1 selects 9x9 sub-multipliers |
| sgn_mode | input | 1 | 1 signed operands, 0 unsigned |
| acc_clr | input | 1 | Load accumulators with the current sum (priority) |
| acc_en | input | 1 | Add the current sum to the accumulators |
| opa | input | 72 | Packed A operands |
| opb | input | 72 | Packed B operands |
| result | output | 144 | Registered packed result |

## Verification
Every mode except accumulate is stateless, so a wrong partial product, field offset or extension shows up in `result` on the edge after the operands arrive. The bench compares the whole 144-bit word every cycle against a model built from plain wide integers. Accumulator faults persist from cycle to cycle, so a wrong clear priority, a lost hold or a missed wrap can stay hidden until mode 3 is selected again. For that reason the bench revisits accumulate mode after runs of other modes, and it drives about 33,000 maximal unsigned additions so that the accumulators pass through 2^52.

// File: rtl/mma_pkg.sv
package mma_pkg;
  localparam int LANE_W  = 18;
  localparam int HALF_W  = LANE_W / 2;
  localparam int N_LANE  = 4;
  localparam int N_ACC   = 2;
  localparam int ACC_W   = 52;
  localparam int OPND_W  = LANE_W * N_LANE;
  localparam int OUT_W   = 2 * OPND_W;
  localparam int WIDE_W  = 4 * LANE_W;
  localparam int PROD_W  = 2 * LANE_W + 2;
  localparam int HPROD_W = 2 * HALF_W + 2;
  localparam int SUM_W   = PROD_W + 2;
  localparam int TOT_W   = SUM_W + 1;

  typedef enum logic [2:0] {
    MD_MUL  = 3'd0,
    MD_SUM2 = 3'd1,
    MD_SUM4 = 3'd2,
    MD_MAC  = 3'd3,
    MD_WIDE = 3'd4
  } mode_e;

  // Exact product of two 18-bit operands, each optionally signed.
  function automatic logic signed [PROD_W-1:0] lane_mul(input logic [LANE_W-1:0] x,
                                                       input logic [LANE_W-1:0] y,
                                                       input logic sx, input logic sy);
    logic signed [LANE_W:0] xe, ye;
    xe = {sx & x[LANE_W-1], x};
    ye = {sy & y[LANE_W-1], y};
    return xe * ye;
  endfunction

  // Exact product of two 9-bit operands.
  function automatic logic signed [HPROD_W-1:0] half_mul(input logic [HALF_W-1:0] x,
                                                        input logic [HALF_W-1:0] y,
                                                        input logic sx, input logic sy);
    logic signed [HALF_W:0] xe, ye;
    xe = {sx & x[HALF_W-1], x};
    ye = {sy & y[HALF_W-1], y};
    return xe * ye;
  endfunction
endpackage

// File: rtl/mma_lane.sv
module mma_lane
  import mma_pkg::*;
(
  input  logic [LANE_W-1:0]         x,
  input  logic [LANE_W-1:0]         y,
  input  logic                      sx,
  input  logic                      sy,
  input  logic                      narrow,
  output logic signed [PROD_W-1:0]  full,
  output logic signed [PROD_W-1:0]  lane_val,
  output logic signed [HPROD_W-1:0] half_p [2]
);
  localparam int HX = PROD_W - HPROD_W;

  assign full = lane_mul(x, y, sx, sy);

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_p[h] = half_mul(x[h*HALF_W +: HALF_W], y[h*HALF_W +: HALF_W], sx, sy);
  end

  logic signed [PROD_W-1:0] half_sum;
  assign half_sum = {{HX{half_p[0][HPROD_W-1]}}, half_p[0]}
                  + {{HX{half_p[1][HPROD_W-1]}}, half_p[1]};
  assign lane_val = narrow ? half_sum : full;

  // R13: unsigned operands never give a negative exact product
  always_comb begin
    if (!sx && !sy)
      a_r13_unsigned_nonneg: assert (!full[PROD_W-1] && !half_p[0][HPROD_W-1]
                                     && !half_p[1][HPROD_W-1]);
  end
endmodule

// File: rtl/mma_wide.sv
module mma_wide
  import mma_pkg::*;
(
  input  logic signed [PROD_W-1:0] pp [N_LANE],
  output logic [WIDE_W-1:0]        prod
);
  localparam int PX = WIDE_W - PROD_W;

  logic [WIDE_W-1:0] term [N_LANE];

  // Lane k holds A half (k%2) times B half (k/2), weighted accordingly.
  for (genvar k = 0; k < N_LANE; k++) begin : g_term
    localparam int SH = LANE_W * ((k % 2) + (k / 2));
    assign term[k] = {{PX{pp[k][PROD_W-1]}}, pp[k]} << SH;
  end

  always_comb begin
    prod = '0;
    for (int k = 0; k < N_LANE; k++) prod = prod + term[k];
  end
endmodule

// File: rtl/mma_acc.sv
module mma_acc
  import mma_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     active,
  input  logic                     clr,
  input  logic                     en,
  input  logic signed [SUM_W-1:0]  sum_in  [N_ACC],
  output logic [ACC_W-1:0]         acc_nxt [N_ACC],
  output logic [ACC_W-1:0]         acc_q   [N_ACC]
);
  localparam int AX = ACC_W - SUM_W;

  logic do_load, do_add;
  assign do_load = active && clr;
  assign do_add  = active && en && !clr;

  for (genvar j = 0; j < N_ACC; j++) begin : g_acc
    logic [ACC_W-1:0] addend;
    assign addend = {{AX{sum_in[j][SUM_W-1]}}, sum_in[j]};

    always_comb begin
      if (do_load)     acc_nxt[j] = addend;
      else if (do_add) acc_nxt[j] = acc_q[j] + addend;
      else             acc_nxt[j] = acc_q[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q[j] <= '0;
      else        acc_q[j] <= acc_nxt[j];
    end

    // R9: clear wins over enable and loads the sum
    a_r9_clear_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (active && clr) |=> acc_q[j][SUM_W-1:0] == $past(sum_in[j]));
    // R10: hold outside accumulate mode or with both controls low
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!active || (!clr && !en)) |=> $stable(acc_q[j]));
    // R11: add wraps modulo 2^ACC_W
    a_r11_wrap_add: assert property (@(posedge clk) disable iff (!rst_n)
      (active && en && !clr) |=> (acc_q[j] - $past(acc_q[j])) == ACC_W'($past(sum_in[j])));
  end
endmodule

// File: rtl/mul_mode_array.sv
module mul_mode_array
  import mma_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode_sel,
  input  logic                narrow,
  input  logic                sgn_mode,
  input  logic                acc_clr,
  input  logic                acc_en,
  input  logic [OPND_W-1:0]   opa,
  input  logic [OPND_W-1:0]   opb,
  output logic [OUT_W-1:0]    result
);
  localparam int F2  = OUT_W / 2;
  localparam int F4  = OUT_W / 4;
  localparam int F8  = OUT_W / 8;
  localparam int X2  = F2 - SUM_W;
  localparam int XT  = OUT_W - TOT_W;
  localparam int XA  = F2 - ACC_W;
  localparam int XW  = OUT_W - WIDE_W;

  mode_e md;
  assign md = mode_e'(mode_sel);
  logic wide_sel;
  assign wide_sel = (md == MD_WIDE);

  logic signed [PROD_W-1:0]  full    [N_LANE];
  logic signed [PROD_W-1:0]  lv      [N_LANE];
  logic signed [HPROD_W-1:0] hp      [N_LANE][2];

  for (genvar k = 0; k < N_LANE; k++) begin : g_lane
    localparam int AI = k % 2;
    localparam int BI = k / 2;
    logic [LANE_W-1:0] lx, ly;
    logic              lsx, lsy;
    assign lx  = wide_sel ? opa[AI*LANE_W +: LANE_W] : opa[k*LANE_W +: LANE_W];
    assign ly  = wide_sel ? opb[BI*LANE_W +: LANE_W] : opb[k*LANE_W +: LANE_W];
    assign lsx = sgn_mode & (!wide_sel || AI == 1);
    assign lsy = sgn_mode & (!wide_sel || BI == 1);
    mma_lane u_lane (
      .x(lx), .y(ly), .sx(lsx), .sy(lsy), .narrow(narrow),
      .full(full[k]), .lane_val(lv[k]), .half_p(hp[k])
    );
  end

  logic [WIDE_W-1:0] wide_prod;
  mma_wide u_wide (.pp(full), .prod(wide_prod));

  // Pair sums: lanes 0+1 and 2+3 (in 9-bit mode each lane already sums its halves)
  logic signed [SUM_W-1:0] hs [N_ACC];
  for (genvar j = 0; j < N_ACC; j++) begin : g_pair
    assign hs[j] = {{2{lv[2*j][PROD_W-1]}}, lv[2*j]} + {{2{lv[2*j+1][PROD_W-1]}}, lv[2*j+1]};
  end
  logic signed [TOT_W-1:0] tot;
  assign tot = {hs[0][SUM_W-1], hs[0]} + {hs[1][SUM_W-1], hs[1]};

  logic [ACC_W-1:0] acc_nxt [N_ACC];
  logic [ACC_W-1:0] acc_q   [N_ACC];
  mma_acc u_acc (
    .clk(clk), .rst_n(rst_n), .active(md == MD_MAC), .clr(acc_clr), .en(acc_en),
    .sum_in(hs), .acc_nxt(acc_nxt), .acc_q(acc_q)
  );

  logic [OUT_W-1:0] res_d;
  always_comb begin
    res_d = '0;
    case (md)
      MD_SUM2: begin
        if (narrow) for (int k = 0; k < N_LANE; k++) res_d[k*F4 +: F4] = lv[k][F4-1:0];
        else for (int j = 0; j < N_ACC; j++) res_d[j*F2 +: F2] = {{X2{hs[j][SUM_W-1]}}, hs[j]};
      end
      MD_SUM4: begin
        if (narrow) for (int j = 0; j < N_ACC; j++) res_d[j*F2 +: F2] = {{X2{hs[j][SUM_W-1]}}, hs[j]};
        else res_d = {{XT{tot[TOT_W-1]}}, tot};
      end
      MD_MAC:
        for (int j = 0; j < N_ACC; j++)
          res_d[j*F2 +: F2] = {{XA{sgn_mode & acc_nxt[j][ACC_W-1]}}, acc_nxt[j]};
      MD_WIDE: res_d = {{XW{sgn_mode & wide_prod[WIDE_W-1]}}, wide_prod};
      default: begin
        if (narrow) begin
          for (int k = 0; k < N_LANE; k++)
            for (int h = 0; h < 2; h++) res_d[(2*k+h)*F8 +: F8] = hp[k][h][F8-1:0];
        end else
          for (int k = 0; k < N_LANE; k++) res_d[k*F4 +: F4] = full[k][F4-1:0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else        result <= res_d;
  end

  // R2 / R12: wide product appears one edge after its operands
  a_r2_wide_latency: assert property (@(posedge clk) disable iff (!rst_n)
    wide_sel |=> result[WIDE_W-1:0] == $past(wide_prod));
  // R3: lane 0 product lands in the lowest field one edge later
  a_r3_lane0_field: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_MUL && !narrow) |=> result[F4-1:0] == $past(full[0][F4-1:0]));
endmodule

// File: tb/sim_mul_mode_array.sv
`timescale 1ns/1ps
module sim_mul_mode_array;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   mode_sel = 3'd0;
  logic         narrow = 1'b0, sgn_mode = 1'b0, acc_clr = 1'b0, acc_en = 1'b0;
  logic [71:0]  opa = '0, opb = '0;
  logic [143:0] result;

  int checks = 0, errors = 0, cyc = 0;
  bit armed = 0, done = 0;

  mul_mode_array u0 (.clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .narrow(narrow),
                     .sgn_mode(sgn_mode), .acc_clr(acc_clr), .acc_en(acc_en),
                     .opa(opa), .opb(opb), .result(result));

  always #2.5 clk = ~clk;

  // Exact value of a w-bit field as a 144-bit signed integer
  function automatic logic signed [143:0] val(input logic [71:0] x, input int w, input bit s);
    logic signed [143:0] r;
    r = '0;
    for (int i = 0; i < w; i++) r[i] = x[i];
    if (s && x[w-1]) for (int i = w; i < 144; i++) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic signed [143:0] prod(input logic [71:0] a, input logic [71:0] b,
                                               input int w, input int idx, input bit s);
    logic [71:0] m;
    m = (72'd1 << w) - 72'd1;
    return val((a >> (w*idx)) & m, w, s) * val((b >> (w*idx)) & m, w, s);
  endfunction

  logic [143:0] exp_res = '0;
  logic [51:0]  macc [2] = '{52'd0, 52'd0};
  string        tag = "R1";

  // Reference model, evaluated on every rising edge
  always @(posedge clk) begin
    logic signed [143:0] t, s2 [2];
    int md;
    armed = 1;
    if (!rst_n) begin
      exp_res = '0; macc[0] = '0; macc[1] = '0; tag = "R1";
    end else begin
      md = mode_sel;
      exp_res = '0;
      case (md)
        1: if (narrow) begin
             tag = "R6";
             for (int j = 0; j < 4; j++) begin
               t = prod(opa, opb, 9, 2*j, sgn_mode) + prod(opa, opb, 9, 2*j+1, sgn_mode);
               exp_res[36*j +: 36] = t[35:0];
             end
           end else begin
             tag = "R5";
             for (int j = 0; j < 2; j++) begin
               t = prod(opa, opb, 18, 2*j, sgn_mode) + prod(opa, opb, 18, 2*j+1, sgn_mode);
               exp_res[72*j +: 72] = t[71:0];
             end
           end
        2: begin
             tag = "R7";
             if (narrow) for (int j = 0; j < 2; j++) begin
               t = 0;
               for (int i = 0; i < 4; i++) t = t + prod(opa, opb, 9, 4*j+i, sgn_mode);
               exp_res[72*j +: 72] = t[71:0];
             end else begin
               t = 0;
               for (int i = 0; i < 4; i++) t = t + prod(opa, opb, 18, i, sgn_mode);
               exp_res = t;
             end
           end
        3: begin
             for (int j = 0; j < 2; j++) begin
               s2[j] = 0;
               if (narrow) for (int i = 0; i < 4; i++) s2[j] = s2[j] + prod(opa, opb, 9, 4*j+i, sgn_mode);
               else s2[j] = prod(opa, opb, 18, 2*j, sgn_mode) + prod(opa, opb, 18, 2*j+1, sgn_mode);
               if (acc_clr) macc[j] = s2[j][51:0];
               else if (acc_en) macc[j] = macc[j] + s2[j][51:0];
               t = val({20'd0, macc[j]}, 52, sgn_mode);
               exp_res[72*j +: 72] = t[71:0];
             end
             tag = acc_clr ? "R9" : (acc_en ? "R8 R11" : "R10");
           end
        4: begin
             tag = "R12";
             exp_res = val(opa & 72'hF_FFFF_FFFF, 36, sgn_mode) * val(opb & 72'hF_FFFF_FFFF, 36, sgn_mode);
           end
        default: if (narrow) begin
             tag = "R4";
             for (int j = 0; j < 8; j++) begin
               t = prod(opa, opb, 9, j, sgn_mode); exp_res[18*j +: 18] = t[17:0];
             end
           end else begin
             tag = (md == 0) ? "R3" : "R3 R10";
             for (int k = 0; k < 4; k++) begin
               t = prod(opa, opb, 18, k, sgn_mode); exp_res[36*k +: 36] = t[35:0];
             end
           end
      endcase
      if (sgn_mode) tag = {tag, " R13"};
    end
  end

  // Compare every cycle, away from the rising edge (R2: one-cycle latency)
  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (result !== exp_res) begin
        errors++;
        $display("FAIL %s R2 cycle %0d: got %h expected %h", tag, cyc, result, exp_res);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog R2: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drive(input logic [2:0] m, input bit n, input bit s, input bit c, input bit e,
                       input logic [71:0] a, input logic [71:0] b);
    @(negedge clk);
    mode_sel = m; narrow = n; sgn_mode = s; acc_clr = c; acc_en = e; opa = a; opb = b;
  endtask

  function automatic logic [71:0] rnd72();
    return {8'($urandom), $urandom, $urandom};
  endfunction

  localparam logic [71:0] ONES = '1;
  localparam logic [71:0] MINS = {4{18'h20000}};
  localparam logic [71:0] HMIN = {8{9'h100}};

  initial begin
    repeat (3) @(negedge clk);                       // R1 checked during reset
    rst_n = 1'b1;
    foreach (MINS[i]) begin end
    for (int m = 0; m < 5; m++) begin
      if (m == 3) continue;
      for (int n = 0; n < 2; n++)
        for (int s = 0; s < 2; s++) begin
          for (int r = 0; r < 6; r++) drive(3'(m), n[0], s[0], 0, 0, rnd72(), rnd72());
          drive(3'(m), n[0], s[0], 0, 0, ONES, ONES);
          drive(3'(m), n[0], s[0], 0, 0, MINS, ONES);
          drive(3'(m), n[0], s[0], 0, 0, HMIN, HMIN);
          drive(3'(m), n[0], s[0], 0, 0, MINS, MINS);
        end
    end
    // Accumulate: clear, add, hold, clear-with-enable (R8 R9 R10)
    for (int n = 0; n < 2; n++)
      for (int s = 0; s < 2; s++) begin
        drive(3'd3, n[0], s[0], 1, 0, rnd72(), rnd72());
        for (int r = 0; r < 5; r++) drive(3'd3, n[0], s[0], 0, 1, rnd72(), rnd72());
        for (int r = 0; r < 3; r++) drive(3'd3, n[0], s[0], 0, 0, rnd72(), rnd72());
        drive(3'd3, n[0], s[0], 1, 1, rnd72(), rnd72());
        drive(3'd3, n[0], s[0], 0, 1, MINS, ONES);
        // other modes must not disturb the accumulators (R10)
        for (int r = 0; r < 3; r++) drive(3'd0, n[0], s[0], 1, 1, rnd72(), rnd72());
        drive(3'd3, n[0], s[0], 0, 0, rnd72(), rnd72());
      end
    for (int m = 5; m < 8; m++) drive(3'(m), 0, 1, 0, 1, rnd72(), rnd72());
    drive(3'd3, 0, 0, 0, 0, rnd72(), rnd72());
    // Wrap modulo 2^52 with maximal unsigned sums (R11)
    drive(3'd3, 0, 0, 1, 0, ONES, ONES);
    for (int r = 0; r < 33000; r++) drive(3'd3, 0, 0, 0, 1, ONES, ONES);
    drive(3'd3, 0, 1, 0, 0, rnd72(), rnd72());
    drive(3'd4, 1, 1, 0, 0, ONES, ONES);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule